// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds two 8-bit interval timers that count down on clock-enable strobes and raise a sticky interrupt each time they wrap. Both timers are set up through one shared control word. Each write to that word changes the settings of both timers at once. For each timer the word carries a reload divider, a halt/count mode bit, a strobe-source select bit and an interrupt-acknowledge bit. A single extra bit chains the two timers, so that timer 0 counts the wraps of timer 1 instead of a strobe.

Each timer has two states. In **HALT** it holds its counter. A write with the mode bit at 0 enters or stays in HALT and loads the divider into the counter (the *load* transition). A write with the mode bit at 1 moves HALT to **COUNT** (the *start* transition). In COUNT, each selected strobe lowers the counter by one. A strobe that arrives while the counter is 1 reloads the divider and sets the interrupt (the *wrap* transition, which stays in COUNT). A write with the mode bit at 0 moves COUNT back to HALT (the *stop* transition). With a 25 kHz strobe and a divider of 250, the interrupt rate is 100 Hz. Software reads both live counts at any time.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counts read 0, both timers are in HALT and both interrupt outputs are low.
- R2: A control write whose mode bit is 0 for a timer puts it in HALT and loads its divider into its count. While in HALT the count ignores every strobe.
- R3: A timer in COUNT decrements by exactly one on each pulse of its selected strobe and holds its count in cycles without one.
- R4: A strobe that arrives while the count is 1 reloads the divider, and the timer's interrupt output goes high on that same clock edge.
- R5: A divider of 0 acts as 256. The count wraps 255, ..., 1 and the timer interrupts once per 256 strobes.
- R6: An interrupt stays high until a control write carries 1 in that timer's acknowledge bit. A write with 0 there leaves it unchanged.
- R7: The source bit chooses the strobe: 0 selects `tick_a`, 1 selects `tick_b`. Pulses on the other input have no effect.
- R8: When the chain bit (word bit 22) is 1, timer 0 ignores its strobe inputs and decrements once for each wrap of timer 1.
- R9: The word layout is as follows. Timer 0 uses bits [10:0] and timer 1 uses bits [21:11]. Within each 11-bit field, bits [7:0] are the divider, bit 8 is the mode (1 = count), bit 9 is the source and bit 10 is the acknowledge bit. One write updates both timers.
- R10: If a wrap and an acknowledge hit the same timer in the same cycle, the interrupt stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 23 | Control word |
| tick_a | input | 1 | Clock-enable strobe, source A |
| tick_b | input | 1 | Clock-enable strobe, source B |
| irq | output | 2 | Sticky interrupt flag per timer |
| count0 | output | 8 | Live count of timer 0 |
| count1 | output | 8 | Live count of timer 1 |

## Verification
The assertions check the following on every cycle in which no write arrives:
- a halted count never moves;
- a counting timer steps down by one on a strobe and holds without one;
- a wrap always leaves the interrupt high;
- an interrupt never drops except through an acknowledge write.

Other behaviours can only be shown by the bench's scenarios, because they depend on exact values over whole sequences:
- the reload value after a wrap;
- the 256-strobe period of a zero divider;
- source selection;
- the chained rate;
- the update of both timers by a single write.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int CNT_W = 8;

    typedef enum logic {
        TM_HALT  = 1'b0,
        TM_COUNT = 1'b1
    } tm_state_e;

    // one timer's slice of the control word, MSB first
    typedef struct packed {
        logic             ack;
        logic             src_b;
        logic             run;
        logic [CNT_W-1:0] reload;
    } tm_field_t;

    localparam int FIELD_W = $bits(tm_field_t);
    localparam int N_TMR   = 2;
    localparam int CTL_W   = N_TMR * FIELD_W + 1;
endpackage

// File: rtl/tick_select.sv
module tick_select #(
    parameter bit CHAIN_OK = 1'b0
) (
    input  logic src_a,
    input  logic src_b,
    input  logic sel_b,
    input  logic chain_en,
    input  logic chain_tick,
    output logic tick
);
    logic ext_tick;
    assign ext_tick = sel_b ? src_b : src_a;

    generate
        if (CHAIN_OK) begin : g_chain
            assign tick = chain_en ? chain_tick : ext_tick;
        end else begin : g_plain
            logic unused_chain;
            assign unused_chain = chain_en ^ chain_tick;
            assign tick = ext_tick;
        end
    endgenerate
endmodule

// File: rtl/down_timer.sv
module down_timer
    import itmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  tm_field_t        field,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             wrap
);
    tm_state_e        state_q, state_d;
    logic [CNT_W-1:0] count_q, reload_q;
    logic             irq_q;
    logic             load_req;

    assign load_req = we && !field.run;
    assign wrap     = (state_q == TM_COUNT) && tick &&
                      (count_q == CNT_W'(1)) && !load_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TM_HALT:  if (we && field.run) state_d = TM_COUNT;
            TM_COUNT: if (load_req)        state_d = TM_HALT;
            default:                       state_d = TM_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TM_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (we) reload_q <= field.reload;
            if (load_req)
                count_q <= field.reload;
            else if (state_q == TM_COUNT && tick)
                count_q <= wrap ? reload_q : count_q - CNT_W'(1);
            if (wrap)
                irq_q <= 1'b1;
            else if (we && field.ack)
                irq_q <= 1'b0;
        end
    end

    assign count = count_q;
    assign irq   = irq_q;

    // R2: halted counter is frozen
    a_r2_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TM_HALT && !we) |=> $stable(count_q));
    // R3: one step per strobe
    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TM_COUNT && !we && tick && count_q != CNT_W'(1))
        |=> count_q == $past(count_q) - CNT_W'(1));
    // R3: no strobe, no motion
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TM_COUNT && !we && !tick) |=> $stable(count_q));
    // R4 / R10: a wrap always leaves the interrupt raised
    a_r4_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> irq_q);
    // R6: only an acknowledge can lower the interrupt
    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !(we && field.ack)) |=> irq_q);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import itmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             tick_a,
    input  logic             tick_b,
    output logic [N_TMR-1:0] irq,
    output logic [CNT_W-1:0] count0,
    output logic [CNT_W-1:0] count1
);
    localparam int CHAIN_BIT = N_TMR * FIELD_W;

    logic                   chain_en;
    logic [N_TMR-1:0]       tick_v;
    logic [N_TMR-1:0]       wrap_v;
    logic [CNT_W-1:0]       cnt_v [N_TMR];

    assign chain_en = ctl_wdata[CHAIN_BIT];

    // chain setting is held in a register; only written on ctl_we
    logic chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain_q <= 1'b0;
        else if (ctl_we) chain_q <= chain_en;
    end

    generate
        for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
            tm_field_t fld;
            assign fld = tm_field_t'(ctl_wdata[i*FIELD_W +: FIELD_W]);

            tick_select #(.CHAIN_OK(i == 0)) u_sel (
                .src_a      (tick_a),
                .src_b      (tick_b),
                .sel_b      (u_tmr_src_b),
                .chain_en   (chain_q),
                .chain_tick (wrap_v[(i + 1) % N_TMR]),
                .tick       (tick_v[i])
            );

            // source select latched on each write
            logic u_tmr_src_b;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      u_tmr_src_b <= 1'b0;
                else if (ctl_we) u_tmr_src_b <= fld.src_b;
            end

            down_timer u_tmr (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (ctl_we),
                .field (fld),
                .tick  (tick_v[i]),
                .count (cnt_v[i]),
                .irq   (irq[i]),
                .wrap  (wrap_v[i])
            );
        end
    endgenerate

    assign count0 = cnt_v[0];
    assign count1 = cnt_v[1];

    // R8: in chained mode timer 0 moves only when timer 1 wraps
    a_r8_chain_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_q && !ctl_we && !wrap_v[1]) |=> $stable(count0));
endmodule

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [22:0] ctl_wdata = '0;
    logic        tick_a = 1'b0;
    logic        tick_b = 1'b0;
    logic [1:0]  irq;
    logic [7:0]  count0, count1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dual_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tick_a(tick_a), .tick_b(tick_b), .irq(irq),
        .count0(count0), .count1(count1)
    );

    // R9 layout: {chain, ack1, src1, run1, div1, ack0, src0, run0, div0}
    function automatic logic [22:0] mk(
        input logic [7:0] d0, input logic r0, input logic s0, input logic a0,
        input logic [7:0] d1, input logic r1, input logic s1, input logic a1,
        input logic ch);
        return {ch, a1, s1, r1, d1, a0, s0, r0, d0};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [22:0] w);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic pulse(input bit use_b, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); if (use_b) tick_b = 1'b1; else tick_a = 1'b1;
            @(negedge clk); tick_a = 1'b0; tick_b = 1'b0;
        end
    endtask

    // {divider, strobes, expected count1, expected irq1}
    localparam logic [25:0] VEC [8] = '{
        {8'd10,  9'd3,   8'd7,   1'b0},
        {8'd10,  9'd10,  8'd10,  1'b1},
        {8'd10,  9'd11,  8'd9,   1'b1},
        {8'd1,   9'd1,   8'd1,   1'b1},
        {8'd0,   9'd1,   8'd255, 1'b0},
        {8'd0,   9'd255, 8'd1,   1'b0},
        {8'd0,   9'd256, 8'd0,   1'b1},
        {8'd250, 9'd250, 8'd250, 1'b1}
    };

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 count0", count0, 0);
        chk("R1 count1", count1, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1'b1;
        pulse(0, 2);
        chk("R1 halted after reset", count1, 0);

        // table: R3/R4/R5 on timer 1 via source A
        for (int v = 0; v < 8; v++) begin
            logic [7:0] d; logic [8:0] n; logic [7:0] ec; logic ei;
            {d, n, ec, ei} = VEC[v];
            wr(mk(8'd0, 0, 0, 1, d, 0, 0, 1, 0));
            wr(mk(8'd0, 0, 0, 0, d, 1, 0, 0, 0));
            pulse(0, int'(n));
            chk($sformatf("R3/R4/R5 vec%0d count1", v), count1, ec);
            chk($sformatf("R4/R5 vec%0d irq1", v), irq[1], ei);
        end

        // R6: no-op keeps, ack clears (irq1 is high from last vector)
        wr(mk(8'd0, 0, 0, 0, 8'd5, 0, 0, 0, 0));
        chk("R6 nop keeps irq", irq[1], 1);
        wr(mk(8'd0, 0, 0, 0, 8'd5, 0, 0, 1, 0));
        chk("R6 ack clears irq", irq[1], 0);

        // R2: halted timer ignores strobes, load applied
        chk("R2 load value", count1, 5);
        pulse(0, 3); pulse(1, 3);
        chk("R2 halt holds", count1, 5);

        // R7: source B selected, A ignored
        wr(mk(8'd0, 0, 0, 0, 8'd5, 1, 1, 0, 0));
        pulse(0, 2);
        chk("R7 other source ignored", count1, 5);
        pulse(1, 2);
        chk("R7 selected source counts", count1, 3);

        // R9: one write loads both timers
        wr(mk(8'd40, 0, 0, 1, 8'd60, 0, 0, 1, 0));
        chk("R9 timer0 loaded", count0, 40);
        chk("R9 timer1 loaded", count1, 60);

        // R8: chained mode
        wr(mk(8'd5, 0, 0, 1, 8'd3, 0, 0, 1, 1));
        wr(mk(8'd5, 1, 0, 0, 8'd3, 1, 0, 0, 1));
        pulse(0, 3);
        chk("R8 count1 after wrap", count1, 3);
        chk("R8 count0 one step", count0, 4);
        pulse(0, 2);
        chk("R8 count0 holds between wraps", count0, 4);
        pulse(0, 1);
        chk("R8 count0 second step", count0, 3);
        chk("R8 irq0 still low", irq[0], 0);

        // R10: wrap and ack in the same cycle, set wins
        wr(mk(8'd0, 0, 0, 1, 8'd1, 0, 0, 1, 0));
        wr(mk(8'd0, 0, 0, 0, 8'd1, 1, 0, 0, 0));
        pulse(0, 1);
        chk("R10 irq1 set", irq[1], 1);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = mk(8'd0, 0, 0, 0, 8'd1, 1, 0, 1, 0);
        tick_a = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0; tick_a = 1'b0;
        chk("R10 set beats ack", irq[1], 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule